// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a synthesizable model of a single-port synchronous SRAM. It has one 36-bit data word per address, split into four 9-bit lanes. Each lane holds eight data bits and one parity bit. Address, control and write data are captured in input registers on the rising clock edge. A read returns its word through an output register one edge after the array is accessed. The depth follows a single address-width parameter.

An access begins on a clock where the address strobe is high. It proceeds only if all three chip selects are in their active state on that clock. The global write enable writes the whole word. Without it, the byte-write enable writes only the lanes whose active-low lane selects are low. With neither enable asserted, the access is a read.

The data bus is split pad-style into an input word, an output word and a drive enable. An external three-state buffer uses that enable. The active-low output enable acts on the drive enable without any clock. For one clock after a read is captured out of the deselected state, the drive enable is held low. This keeps the bus floating until the output register holds that read's data.

Top module: `psram_core`

## Requirements
- R1: While reset is high and after it is released, `dq_t` is low and `dq_o` is all zeros until the first read completes.
- R2: A read captured on edge k (strobe high, chips selected, `gwr_n`=1, `bwe_n`=1) presents the addressed word on `dq_o` with `dq_t` high after edge k+1, provided `oe_n` is low.
- R3: A write with `gwr_n` low stores all 36 bits, whatever the values of `bwe_n` and `bsel_n`.
- R4: With `gwr_n` high and `bwe_n` low, only lane i is written where `bsel_n[i]` is low. Lane 0 is bits 8:0, lane 1 is bits 17:9, lane 2 is bits 26:18 and lane 3 is bits 35:27. With all four `bsel_n` bits high, nothing changes.
- R5: A read (`gwr_n`=1, `bwe_n`=1) leaves the stored word unchanged, whatever is on `dq_i`.
- R6: An access happens only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 on a strobe clock. A strobe with any select inactive performs no write, and it leaves `dq_t` low after its edge.
- R7: On a clock with the strobe low, every control and data input is ignored. No write takes place, and `dq_o` is unchanged two edges later.
- R8: `oe_n` high forces `dq_t` low at once, without waiting for a clock edge.
- R9: After a read is captured from the deselected state (including the state after reset), `dq_t` stays low until the next edge. A read captured while already selected keeps the bus driven with the previous data for that clock.
- R10: A read strobed on the clock right after a write to the same address returns the newly written word.
- R11: After the edge that captures a selected write, `dq_t` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| adr_stb | input | 1 | Address strobe, starts an access |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 36 | Write data from the bus |
| dq_o | output | 36 | Read data from the output register |
| dq_t | output | 1 | Bus drive enable, high when driving |

## Verification
The bench stacks partial-lane writes on one word. A mis-mapped lane or an inverted select would corrupt a neighbouring lane's bits or the parity bit. It also checks a global write with every lane select off, so a design that lets the lane selects gate the override stores nothing. The deselect-to-read path is sampled one clock after capture. There, a missing mask shows up as the bus driving stale data, and a mask applied too broadly shows up as a float during a read from the selected state. Back-to-back write and read to one address, writes issued without the strobe, and writes with one select inactive each catch designs that sample controls at the wrong moment or ignore a select.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [WORD_W-1:0] word_t;

    // Access captured by the input stage
    typedef struct packed {
        logic       go;     // strobe with all selects active
        logic       wr;     // write (global or byte)
        lane_mask_t lanes;  // lanes to store on a write
    } acc_t;

    // Output-side selection state, updated on strobe clocks only
    typedef struct packed {
        logic active;       // chip currently selected
        logic rd;           // last selected access was a read
    } mode_t;

    function automatic logic sel_ok(input logic c1n, input logic c2, input logic c3n);
        return !c1n && c2 && !c3n;
    endfunction

    function automatic logic wr_req(input logic g_n, input logic b_n);
        return !g_n || !b_n;
    endfunction

    function automatic lane_mask_t lane_pick(input logic g_n, input logic b_n,
                                             input lane_mask_t s_n);
        lane_mask_t m;
        if (!g_n)      m = '1;
        else if (!b_n) m = ~s_n;
        else           m = '0;
        return m;
    endfunction

endpackage

// File: rtl/psram_in_stage.sv
module psram_in_stage
    import psram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              c1n,
    input  logic              c2,
    input  logic              c3n,
    input  logic              g_n,
    input  logic              b_n,
    input  lane_mask_t        s_n,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output acc_t              acc_q,
    output logic [ADDR_W-1:0] addr_q,
    output word_t             wdata_q,
    output mode_t             mode_q,
    output logic              mask_q
);

    logic chip_on;
    logic is_wr;
    logic take;

    always_comb begin
        chip_on = sel_ok(c1n, c2, c3n);
        is_wr   = wr_req(g_n, b_n);
        take    = stb && chip_on;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            mode_q  <= '0;
            mask_q  <= 1'b0;
        end else begin
            acc_q.go    <= take;
            acc_q.wr    <= is_wr;
            acc_q.lanes <= lane_pick(g_n, b_n, s_n);
            addr_q      <= addr;
            wdata_q     <= wdata;
            // hold the bus off for one clock when a read wakes the chip up
            mask_q      <= take && !is_wr && !mode_q.active;
            if (stb) begin
                mode_q.active <= chip_on;
                if (chip_on) begin
                    mode_q.rd <= !is_wr;
                end
            end
        end
    end

endmodule

// File: rtl/psram_lane_ram.sv
module psram_lane_ram
    import psram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wd,
    output logic [LANE_W-1:0] rd_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wd;
        end
    end

    // output register of the read pipeline
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (re) begin
            rd_q <= mem[addr];
        end
    end

endmodule

// File: rtl/psram_out_stage.sv
module psram_out_stage
    import psram_pkg::*;
(
    input  logic  oe_n,
    input  mode_t mode_q,
    input  logic  mask_q,
    input  word_t rdata,
    output word_t dq_o,
    output logic  dq_t
);

    always_comb begin
        dq_o = rdata;
        dq_t = !oe_n && mode_q.active && mode_q.rd && !mask_q;
    end

endmodule

// File: rtl/psram_core.sv
module psram_core
    import psram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adr_stb,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              gwr_n,
    input  logic              bwe_n,
    input  logic [3:0]        bsel_n,
    input  logic              oe_n,
    input  logic [35:0]       dq_i,
    output logic [35:0]       dq_o,
    output logic              dq_t
);

    acc_t              acc_q;
    logic [ADDR_W-1:0] addr_q;
    word_t             wdata_q;
    mode_t             mode_q;
    logic              mask_q;
    word_t             rdata;

    psram_in_stage #(.ADDR_W(ADDR_W)) u_in (
        .clk     (clk),
        .rst     (rst),
        .stb     (adr_stb),
        .c1n     (cs1_n),
        .c2      (cs2),
        .c3n     (cs3_n),
        .g_n     (gwr_n),
        .b_n     (bwe_n),
        .s_n     (bsel_n),
        .addr    (addr),
        .wdata   (dq_i),
        .acc_q   (acc_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .mode_q  (mode_q),
        .mask_q  (mask_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        psram_lane_ram #(.ADDR_W(ADDR_W)) u_ram (
            .clk  (clk),
            .rst  (rst),
            .we   (acc_q.go && acc_q.wr && acc_q.lanes[g]),
            .re   (acc_q.go && !acc_q.wr),
            .addr (addr_q),
            .wd   (wdata_q[g*LANE_W +: LANE_W]),
            .rd_q (rdata[g*LANE_W +: LANE_W])
        );
    end

    psram_out_stage u_out (
        .oe_n   (oe_n),
        .mode_q (mode_q),
        .mask_q (mask_q),
        .rdata  (rdata),
        .dq_o   (dq_o),
        .dq_t   (dq_t)
    );

endmodule

// File: rtl/psram_core_chk.sv
module psram_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        adr_stb,
    input logic        cs1_n,
    input logic        cs2,
    input logic        cs3_n,
    input logic        gwr_n,
    input logic        bwe_n,
    input logic        oe_n,
    input logic [35:0] dq_o,
    input logic        dq_t
);

    logic chip_on;
    logic is_wr;

    always_comb begin
        chip_on = !cs1_n && cs2 && !cs3_n;
        is_wr   = !gwr_n || !bwe_n;
    end

    assert_oe_float_R8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_t);

    assert_write_float_R11: assert property (@(posedge clk) disable iff (rst)
        (adr_stb && chip_on && is_wr) |=> !dq_t);

    assert_desel_float_R6: assert property (@(posedge clk) disable iff (rst)
        (adr_stb && !chip_on) |=> !dq_t);

    assert_wake_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (adr_stb && !chip_on) ##1 (adr_stb && chip_on && !is_wr) |=> !dq_t);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !adr_stb |-> ##2 $stable(dq_o));

endmodule

bind psram_core psram_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .adr_stb (adr_stb),
    .cs1_n   (cs1_n),
    .cs2     (cs2),
    .cs3_n   (cs3_n),
    .gwr_n   (gwr_n),
    .bwe_n   (bwe_n),
    .oe_n    (oe_n),
    .dq_o    (dq_o),
    .dq_t    (dq_t)
);

// File: tb/psram_core_tb.sv
`timescale 1ns/100ps
module psram_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  addr = '0;
    logic        adr_stb = 1'b0;
    logic        cs1_n = 1'b0;
    logic        cs2 = 1'b1;
    logic        cs3_n = 1'b0;
    logic        gwr_n = 1'b1;
    logic        bwe_n = 1'b1;
    logic [3:0]  bsel_n = 4'hF;
    logic        oe_n = 1'b0;
    logic [35:0] dq_i = '0;
    logic [35:0] dq_o;
    logic        dq_t;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    psram_core #(.ADDR_W(10)) u_dut (
        .clk (clk), .rst (rst), .addr (addr), .adr_stb (adr_stb),
        .cs1_n (cs1_n), .cs2 (cs2), .cs3_n (cs3_n),
        .gwr_n (gwr_n), .bwe_n (bwe_n), .bsel_n (bsel_n),
        .oe_n (oe_n), .dq_i (dq_i), .dq_o (dq_o), .dq_t (dq_t)
    );

    // {rd, gwr_n, bwe_n, bsel_n, addr, wdata, expected}
    localparam int NV = 14;
    localparam logic [88:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b1, 4'b1111, 10'd5,    36'h123456789, 36'h0},          // R3 global
        {1'b1, 1'b1, 1'b1, 4'b1111, 10'd5,    36'h0,         36'h123456789},
        {1'b0, 1'b1, 1'b0, 4'b1110, 10'd5,    36'hFFFFFFFFF, 36'h0},          // R4 lane 0
        {1'b1, 1'b1, 1'b1, 4'b1111, 10'd5,    36'h0,         36'h1234567FF},
        {1'b0, 1'b1, 1'b0, 4'b0101, 10'd5,    36'h000000000, 36'h0},          // R4 lanes 1,3
        {1'b1, 1'b1, 1'b1, 4'b1111, 10'd5,    36'h0,         36'h0034401FF},
        {1'b0, 1'b0, 1'b0, 4'b1111, 10'd6,    36'h987654321, 36'h0},          // R3 override
        {1'b1, 1'b1, 1'b1, 4'b1111, 10'd6,    36'h0,         36'h987654321},
        {1'b0, 1'b1, 1'b0, 4'b1111, 10'd6,    36'h000000000, 36'h0},          // R4 no lanes
        {1'b1, 1'b1, 1'b1, 4'b1111, 10'd6,    36'hFFFFFFFFF, 36'h987654321},  // R5
        {1'b1, 1'b1, 1'b1, 4'b0000, 10'd6,    36'hFFFFFFFFF, 36'h987654321},  // R5
        {1'b0, 1'b0, 1'b1, 4'b1111, 10'd1023, 36'h5A5A5A5A5, 36'h0},
        {1'b1, 1'b1, 1'b1, 4'b1111, 10'd1023, 36'h0,         36'h5A5A5A5A5},
        {1'b1, 1'b1, 1'b1, 4'b1111, 10'd5,    36'h0,         36'h0034401FF}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [36:0] act, input logic [36:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic stb, input logic c1n, input logic c2v, input logic c3n,
                       input logic g, input logic b, input logic [3:0] s,
                       input logic [9:0] a, input logic [35:0] d);
        adr_stb = stb; cs1_n = c1n; cs2 = c2v; cs3_n = c3n;
        gwr_n = g; bwe_n = b; bsel_n = s; addr = a; dq_i = d;
    endtask

    task automatic idle();
        adr_stb = 1'b0; gwr_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
        cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0; dq_i = '0;
    endtask

    task automatic rd2(input logic [9:0] a);
        put(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, a, '0);
        tick();
        idle();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        chk("R1 reset held", {dq_t, dq_o}, {1'b0, 36'h0});
        rst = 1'b0;
        tick();
        chk("R1 after reset", {dq_t, dq_o}, {1'b0, 36'h0});

        // table walk
        for (int i = 0; i < NV; i++) begin
            put(1'b1, 1'b0, 1'b1, 1'b0, VEC[i][87], VEC[i][86], VEC[i][85:82],
                VEC[i][81:72], VEC[i][71:36]);
            tick();
            idle();
            tick();
            if (VEC[i][88]) begin
                chk($sformatf("R2/R3/R4/R5 table entry %0d", i),
                    {dq_t, dq_o}, {1'b1, VEC[i][35:0]});
            end
        end

        // R8: output enable acts without a clock
        oe_n = 1'b1;
        #1;
        chk("R8 oe high floats", {36'h0, dq_t}, {36'h0, 1'b0});
        oe_n = 1'b0;
        #1;
        chk("R8 oe low drives", {36'h0, dq_t}, {36'h0, 1'b1});
        @(negedge clk);

        // R6: write with cs1_n inactive is dropped and deselects
        put(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 10'd5, 36'h0);
        tick();
        chk("R6 deselect floats", {36'h0, dq_t}, {36'h0, 1'b0});
        idle();
        tick();

        // R9: read waking from deselect is masked for one clock
        put(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 10'd5, '0);
        tick();
        chk("R9 masked first clock", {36'h0, dq_t}, {36'h0, 1'b0});
        put(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 10'd6, '0);
        tick();
        chk("R6 dropped write kept data", {dq_t, dq_o}, {1'b1, 36'h0034401FF});
        idle();
        chk("R9 selected read keeps driving old data", {dq_t, dq_o}, {1'b1, 36'h0034401FF});
        tick();
        chk("R2 back-to-back read", {dq_t, dq_o}, {1'b1, 36'h987654321});

        // R6: cs3_n inactive, then cs2 inactive
        put(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 10'd6, 36'h0);
        tick();
        put(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 10'd6, 36'h0);
        tick();
        idle();
        tick();
        rd2(10'd6);
        chk("R6 cs3/cs2 inactive writes dropped", {dq_t, dq_o}, {1'b1, 36'h987654321});

        // R7: write-looking controls without the strobe
        put(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 10'd6, 36'h0);
        tick();
        idle();
        tick();
        chk("R7 no strobe output held", {dq_t, dq_o}, {1'b1, 36'h987654321});
        rd2(10'd6);
        chk("R7 no strobe write ignored", {dq_t, dq_o}, {1'b1, 36'h987654321});

        // R11 then R10: write followed at once by read of the same word
        put(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 10'd7, 36'h111111111);
        tick();
        chk("R11 write floats bus", {36'h0, dq_t}, {36'h0, 1'b0});
        rd2(10'd7);
        chk("R10 read after write", {dq_t, dq_o}, {1'b1, 36'h111111111});

        // R1: reset again clears the drive state
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        chk("R1 second reset", {dq_t, dq_o}, {1'b0, 36'h0});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule